// File: doc/BRIEF.md
# Raster Video and Sound Scan Timing Generator

The block paces the scan of a 512 x 342 one-bit-per-pixel bitmap display whose frame buffer lives in the same DRAM as the CPU. It runs from a 16 MHz system clock and divides it internally into 8, 4, 2 and 1 MHz phase clocks. One period of the 1 MHz clock is one memory slot. A line is 44 slots long. Slots 0 to 31 each fetch one 16-bit video word, which gives 32 words or 512 pixels per line. Slots 32 to 42 are horizontal retrace. Slot 43 is reserved on every line for one sound-sample fetch.

A frame is 342 active lines followed by 28 vertical retrace lines, 370 lines in total. On retrace lines only the sound fetch is issued. The video word address steps by one word per fetch, starting at a frame base on the first active line. A full frame therefore walks through enough low address bits to refresh the DRAM as a side effect. The sound address starts at its own base and steps by one word per line.

Downstream logic uses the fetch requests and addresses to schedule DRAM reads. It uses the load strobe to copy the fetched word into the pixel shifter, and sends the sync outputs to the monitor.

Top module: `rscan_timer`

## Requirements
- R1: While `rst_n` is low, every output strobe, request, sync and blank is 0. On the first clock after release the block is at slot 0 of line 0 and `vid_req` is 1 with `vid_addr` equal to VID_BASE.
- R2: A slot lasts SLOT_CLKS (16) clocks and a line lasts LINE_SLOTS (44) slots. On an active line, `vid_req` is high only in the first clock of each of slots 0..ACTIVE_SLOTS-1 (0..31), once per slot.
- R3: While `vid_req` is high on line L in slot S, `vid_addr` equals VID_BASE + L*ACTIVE_SLOTS + S.
- R4: `pix_load` is high only in the last clock of each active slot on an active line, one clock after that slot's fetch data is due.
- R5: `hblank` is high for every clock of slots 32..43 and low in slots 0..31, on every line.
- R6: `hsync` is high for every clock of slots HS_FIRST..HS_FIRST+HS_SLOTS-1 (default 34..39) and low otherwise.
- R7: On lines ACTIVE_LINES and above (the vertical retrace lines), `vid_req` and `pix_load` stay low.
- R8: `snd_req` is high in the first clock of slot LINE_SLOTS-1 (43) on every line, retrace lines included, with `snd_addr` equal to SND_BASE + L on line L.
- R9: `vsync` is high for whole lines ACTIVE_LINES+VS_OFS .. ACTIVE_LINES+VS_OFS+VS_LINES-1 and low on all other lines.
- R10: After line TOTAL_LINES-1 (369) the scan returns to line 0. The next video fetch uses VID_BASE again and the next sound fetch uses SND_BASE again.
- R11: Pulling `rst_n` low in the middle of a frame resynchronizes the scan, so that after release the timing is the same as after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Active-low reset |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| hblank | output | 1 | High during the retrace slots of each line |
| vid_req | output | 1 | One-clock video word fetch request |
| vid_addr | output | ADDR_W | Video word address, valid with `vid_req` |
| snd_req | output | 1 | One-clock sound sample fetch request |
| snd_addr | output | ADDR_W | Sound word address, valid with `snd_req` |
| pix_load | output | 1 | One-clock pixel shifter load strobe |

## Verification
The outputs are decoded directly from the phase, slot and line counters. An error in the phase divider therefore moves every request edge within one slot. An error in the slot or line counter shows up at the next line boundary as a shifted `hblank`, `hsync` or `snd_req`, or as a wrong `vsync` line.

The fetch counters are separate state, so they can drift away from the raster counters. A drift shows as a wrong `vid_addr` at the next `vid_req`, or as a wrong `snd_addr` at the next line end. A counter that fails to clear shows at the first fetch after the frame wraps.

The bench compares every output on every clock against a model built from the slot and line arithmetic. A divergence is therefore reported in the cycle it happens.

// File: rtl/rscan_pkg.sv
package rscan_pkg;

  // true when v lies in [first, first+count)
  function automatic bit in_span(int unsigned v, int unsigned first,
                                 int unsigned count);
    return (v >= first) && (v < first + count);
  endfunction

  // word offset of a fetch inside the frame buffer
  function automatic int unsigned word_offset(int unsigned line,
                                              int unsigned slot,
                                              int unsigned per_line);
    return line * per_line + slot;
  endfunction

endpackage

// File: rtl/rscan_phase_div.sv
module rscan_phase_div #(
  parameter int unsigned PH_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_first,
  output logic slot_last
);
  logic [PH_W-1:0] ph;
  logic [PH_W:0]   carry;

  assign carry[0] = 1'b1;

  // each stage halves the rate of the one below it: 8, 4, 2, 1 MHz
  for (genvar i = 0; i < PH_W; i++) begin : g_stage
    assign carry[i+1] = carry[i] & ph[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph[i] <= 1'b0;
      else        ph[i] <= ph[i] ^ carry[i];
    end
  end

  assign slot_first = ~|ph;
  assign slot_last  = carry[PH_W];
endmodule

// File: rtl/rscan_raster_ctr.sv
module rscan_raster_ctr #(
  parameter int unsigned LINE_SLOTS  = 44,
  parameter int unsigned TOTAL_LINES = 370,
  localparam int unsigned SLOT_W = $clog2(LINE_SLOTS),
  localparam int unsigned LINE_W = $clog2(TOTAL_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot,
  output logic [LINE_W-1:0] line,
  output logic              slot_end,
  output logic              frame_end
);
  logic line_end;

  assign slot_end  = (slot == SLOT_W'(LINE_SLOTS - 1));
  assign line_end  = (line == LINE_W'(TOTAL_LINES - 1));
  assign frame_end = slot_end & line_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      line <= '0;
    end else if (adv) begin
      if (slot_end) begin
        slot <= '0;
        line <= line_end ? '0 : line + 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rscan_fetch_ctr.sv
module rscan_fetch_ctr #(
  parameter int unsigned ACTIVE_SLOTS = 32,
  parameter int unsigned ACTIVE_LINES = 342,
  parameter int unsigned TOTAL_LINES  = 370,
  localparam int unsigned VCNT_W = $clog2(ACTIVE_SLOTS * ACTIVE_LINES + 1),
  localparam int unsigned SCNT_W = $clog2(TOTAL_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              fetch_slot,
  input  logic              line_end,
  input  logic              frame_end,
  output logic [VCNT_W-1:0] vcnt,
  output logic [SCNT_W-1:0] scnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt <= '0;
      scnt <= '0;
    end else if (adv) begin
      if (frame_end) begin
        vcnt <= '0;
        scnt <= '0;
      end else begin
        if (fetch_slot) vcnt <= vcnt + 1'b1;
        if (line_end)   scnt <= scnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rscan_timer.sv
module rscan_timer #(
  parameter int unsigned SLOT_CLKS    = 16,
  parameter int unsigned LINE_SLOTS   = 44,
  parameter int unsigned ACTIVE_SLOTS = 32,
  parameter int unsigned HS_FIRST     = 34,
  parameter int unsigned HS_SLOTS     = 6,
  parameter int unsigned ACTIVE_LINES = 342,
  parameter int unsigned TOTAL_LINES  = 370,
  parameter int unsigned VS_OFS       = 4,
  parameter int unsigned VS_LINES     = 3,
  parameter int unsigned ADDR_W       = 22,
  parameter int unsigned VID_BASE     = 32'h0003_A700,
  parameter int unsigned SND_BASE     = 32'h0003_FD00
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              hsync,
  output logic              vsync,
  output logic              hblank,
  output logic              vid_req,
  output logic [ADDR_W-1:0] vid_addr,
  output logic              snd_req,
  output logic [ADDR_W-1:0] snd_addr,
  output logic              pix_load
);
  import rscan_pkg::*;

  localparam int unsigned PH_W   = $clog2(SLOT_CLKS);
  localparam int unsigned SLOT_W = $clog2(LINE_SLOTS);
  localparam int unsigned LINE_W = $clog2(TOTAL_LINES);
  localparam int unsigned VCNT_W = $clog2(ACTIVE_SLOTS * ACTIVE_LINES + 1);
  localparam int unsigned SCNT_W = $clog2(TOTAL_LINES + 1);

  logic              slot_first, slot_last;
  logic [SLOT_W-1:0] slot;
  logic [LINE_W-1:0] line;
  logic              slot_end, frame_end;
  logic              line_active, slot_active, fetch_slot;
  logic [VCNT_W-1:0] vcnt;
  logic [SCNT_W-1:0] scnt;

  rscan_phase_div #(.PH_W(PH_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_first (slot_first),
    .slot_last  (slot_last)
  );

  rscan_raster_ctr #(
    .LINE_SLOTS  (LINE_SLOTS),
    .TOTAL_LINES (TOTAL_LINES)
  ) u_raster (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (slot_last),
    .slot      (slot),
    .line      (line),
    .slot_end  (slot_end),
    .frame_end (frame_end)
  );

  assign line_active = (int'(line) < int'(ACTIVE_LINES));
  assign slot_active = (int'(slot) < int'(ACTIVE_SLOTS));
  assign fetch_slot  = line_active & slot_active;

  rscan_fetch_ctr #(
    .ACTIVE_SLOTS (ACTIVE_SLOTS),
    .ACTIVE_LINES (ACTIVE_LINES),
    .TOTAL_LINES  (TOTAL_LINES)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv        (slot_last),
    .fetch_slot (fetch_slot),
    .line_end   (slot_end),
    .frame_end  (frame_end),
    .vcnt       (vcnt),
    .scnt       (scnt)
  );

  // outputs are decoded from the counters and forced quiet in reset
  assign hblank   = rst_n & ~slot_active;
  assign hsync    = rst_n & in_span(int'(slot), HS_FIRST, HS_SLOTS);
  assign vsync    = rst_n & in_span(int'(line), ACTIVE_LINES + VS_OFS, VS_LINES);
  assign vid_req  = rst_n & fetch_slot & slot_first;
  assign pix_load = rst_n & fetch_slot & slot_last;
  assign snd_req  = rst_n & slot_end & slot_first;
  assign vid_addr = ADDR_W'(VID_BASE) + ADDR_W'(vcnt);
  assign snd_addr = ADDR_W'(SND_BASE) + ADDR_W'(scnt);
endmodule

// File: rtl/rscan_timer_chk.sv
module rscan_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic hsync,
  input logic vsync,
  input logic hblank,
  input logic vid_req,
  input logic snd_req,
  input logic pix_load
);
  // R2
  vid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_req |=> !vid_req);
  // R4
  load_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_req |-> !pix_load);
  // R5
  fetch_in_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_req || pix_load) |-> !hblank);
  // R6
  hsync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> hblank);
  // R8
  snd_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_req |-> (hblank && !vid_req));
  // R7
  no_fetch_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> (!vid_req && !pix_load));
endmodule

bind rscan_timer rscan_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hsync    (hsync),
  .vsync    (vsync),
  .hblank   (hblank),
  .vid_req  (vid_req),
  .snd_req  (snd_req),
  .pix_load (pix_load)
);

// File: tb/rscan_timer_bench.sv
module rscan_timer_bench;
  localparam int unsigned SC  = 16;
  localparam int unsigned LS  = 44;
  localparam int unsigned AS  = 32;
  localparam int unsigned HF  = 34;
  localparam int unsigned HN  = 6;
  localparam int unsigned AL  = 6;
  localparam int unsigned TL  = 10;
  localparam int unsigned VO  = 1;
  localparam int unsigned VN  = 3;
  localparam int unsigned AW  = 22;
  localparam int unsigned VB  = 32'h3000;
  localparam int unsigned SB  = 32'h0100;
  localparam int unsigned LINE_CLKS = SC * LS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync, vsync, hblank, vid_req, snd_req, pix_load;
  logic [AW-1:0] vid_addr, snd_addr;

  int unsigned k = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  rscan_timer #(
    .SLOT_CLKS(SC), .LINE_SLOTS(LS), .ACTIVE_SLOTS(AS), .HS_FIRST(HF),
    .HS_SLOTS(HN), .ACTIVE_LINES(AL), .TOTAL_LINES(TL), .VS_OFS(VO),
    .VS_LINES(VN), .ADDR_W(AW), .VID_BASE(VB), .SND_BASE(SB)
  ) u_rscan_timer (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .hblank(hblank),
    .vid_req(vid_req), .vid_addr(vid_addr), .snd_req(snd_req),
    .snd_addr(snd_addr), .pix_load(pix_load)
  );

  task automatic check_eq(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d (k=%0d)", tag, what, act, exp, k);
    end
  endtask

  // model of every output from the clock count since release
  task automatic compare_now(string ctx);
    int unsigned ph = k % SC;
    int unsigned sl = (k / SC) % LS;
    int unsigned ln = (k / LINE_CLKS) % TL;
    bit act = (ln < AL) && (sl < AS);
    check_eq(ln < AL ? "R2" : "R7", {ctx, " vid_req"}, vid_req, act && ph == 0);
    check_eq(ln < AL ? "R4" : "R7", {ctx, " pix_load"}, pix_load, act && ph == SC - 1);
    check_eq("R5", {ctx, " hblank"}, hblank, sl >= AS);
    check_eq("R6", {ctx, " hsync"}, hsync, sl >= HF && sl < HF + HN);
    check_eq("R9", {ctx, " vsync"}, vsync, ln >= AL + VO && ln < AL + VO + VN);
    check_eq("R8", {ctx, " snd_req"}, snd_req, sl == LS - 1 && ph == 0);
    if (act && ph == 0)
      check_eq("R3", {ctx, " vid_addr"}, vid_addr, VB + ln * AS + sl);
    if (sl == LS - 1 && ph == 0)
      check_eq("R8", {ctx, " snd_addr"}, snd_addr, SB + ln);
  endtask

  task automatic run_cmp(int n, string ctx);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_now(ctx);
    end
  endtask

  task automatic check_quiet(string tag);
    check_eq(tag, "reset vid_req", vid_req, 0);
    check_eq(tag, "reset pix_load", pix_load, 0);
    check_eq(tag, "reset snd_req", snd_req, 0);
    check_eq(tag, "reset hsync", hsync, 0);
    check_eq(tag, "reset vsync", vsync, 0);
    check_eq(tag, "reset hblank", hblank, 0);
  endtask

  // R1: quiet in reset, fetch at base on the first clock after release
  task automatic t_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_quiet("R1");
    end
    rst_n = 1'b1;
    #1;
    check_eq("R1", "first vid_req", vid_req, 1);
    check_eq("R1", "first vid_addr", vid_addr, VB);
    compare_now("R1");
  endtask

  // R2..R6: active lines of the first frame
  task automatic t_active();
    run_cmp(AL * LINE_CLKS - 1, "active");
  endtask

  // R7, R8, R9: vertical retrace lines
  task automatic t_retrace();
    run_cmp((TL - AL) * LINE_CLKS, "retrace");
  endtask

  // R10: second frame starts again at both bases
  task automatic t_wrap();
    run_cmp(1, "R10 wrap");
    check_eq("R10", "wrap vid_addr", vid_addr, VB);
    run_cmp(2 * LINE_CLKS, "R10 frame2");
  endtask

  // R11: reset in the middle of a line resynchronizes the scan
  task automatic t_midreset();
    run_cmp(3 * LINE_CLKS + 200, "pre-reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_quiet("R11");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_quiet("R11");
    end
    rst_n = 1'b1;
    #1;
    check_eq("R11", "resync vid_req", vid_req, 1);
    check_eq("R11", "resync vid_addr", vid_addr, VB);
    run_cmp(2 * LINE_CLKS, "R11");
  endtask

  initial begin
    t_reset();
    t_active();
    t_retrace();
    t_wrap();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule